// File: doc/BRIEF.md
# Instruction Legality Constraint Checker

This block watches a 32-bit instruction word on every clock and reports whether the word belongs to a small permitted subset: register-register arithmetic, register-immediate arithmetic, word load, word store and the canonical no-operation. Its intended use is as an input constraint in formal duplicate-execution checking. There, a tool may only feed the processor instructions the block accepts, and the upper half of the register file is kept free for a shadow copy of the program.

The word is cut into fields at fixed bit positions. Each format gets a gate term made of its opcode and, when the half-register option is on, a bound on every register field that the format actually uses. Each allowed instruction then gets a match term: its format gate ANDed with equalities on its control fields. A field may accept several constants. The matches are ORed into one allowed flag per format, and the flags are ORed into an overall legal flag. All outputs are registered, so they describe the word sampled at the previous rising edge.

The bound checker module contains a generate-selected property. It requires `legal` on every cycle and is enabled by setting `ENFORCE_LEGAL` on the checker. A formal tool can then use it as an assumption.

Top module: `ilc_legality_checker`

## Requirements
- R1: While `rst_n` is low at a rising edge, `fmt_allowed` and `legal` are 0 after that edge.
- R2: Field positions are opcode [6:0], rd [11:7], funct3 [14:12], rs1 [19:15], rs2 [24:20], funct7 [31:25]. With opcode 0x33, funct7 0x00 and funct3 111, 110 or 100 matches, and `fmt_allowed` bit 0 is set. At most one of bits 0..3 is ever set.
- R3: With opcode 0x33 and funct3 000, funct7 may be 0x00 or 0x20. Any other funct7 is rejected, and so is funct7 0x20 with any other funct3.
- R4: Opcode 0x13 with funct3 000, 111, 110 or 100 sets bit 1. Any other funct3 is rejected. The immediate in [31:20] is unconstrained.
- R5: Opcode 0x03 (sets bit 2) and opcode 0x23 (sets bit 3) are accepted only with funct3 010.
- R6: With `HALF_REGS`=1, every register field used by the format must be below `NUM_REGS`/2 (16 by default). The register-register format uses rd, rs1 and rs2. The immediate and load formats use rd and rs1. The store format uses rs1 and rs2. Bits that a format does not use as registers are not bounded.
- R7: The word 0x00000013 sets bit 4 (no-operation). This match uses no format gate term. Any other word leaves bit 4 clear.
- R8: `legal` equals the OR of all `fmt_allowed` bits. Any opcode outside {0x33, 0x13, 0x03, 0x23} gives `legal`=0.
- R9: Outputs after a rising edge reflect the word sampled at that edge. Back-to-back words are judged independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Instruction word under test |
| fmt_allowed | output | 5 | Per-format allowed flags: 0 reg-reg, 1 reg-imm, 2 load, 3 store, 4 no-op |
| legal | output | 1 | OR of all format flags |

## Verification
The bench drives each allowed instruction once with low register numbers, which separates the per-format flags from one another. It then drives near-misses that change exactly one control field (funct7, funct3, opcode), which shows that every equality is really part of each match. Register values of 15, 16, 20 and 31 are placed in used and unused register positions. These separate the half-register bound from a blanket check on every 5-bit slice. The no-op word and a one-bit-off neighbour check that the no-op match is exact, and alternating legal and illegal words on consecutive cycles check the one-cycle latency.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_GATED = 4;   // formats that carry a gate term
    localparam int NUM_FMT   = 5;   // plus the no-op flag

    localparam int FMT_REG   = 0;
    localparam int FMT_IMM   = 1;
    localparam int FMT_LOAD  = 2;
    localparam int FMT_STORE = 3;
    localparam int FMT_NOP   = 4;

    localparam logic [6:0] OPC_REG   = 7'h33;
    localparam logic [6:0] OPC_IMM   = 7'h13;
    localparam logic [6:0] OPC_LOAD  = 7'h03;
    localparam logic [6:0] OPC_STORE = 7'h23;

    // Field layout, most significant first; position is behaviour.
    typedef struct packed {
        logic [6:0] funct7;
        logic [4:0] rs2;
        logic [4:0] rs1;
        logic [2:0] funct3;
        logic [4:0] rd;
        logic [6:0] opcode;
    } insn_fields_t;

    function automatic logic [6:0] fmt_opcode(input int f);
        case (f)
            FMT_REG:  return OPC_REG;
            FMT_IMM:  return OPC_IMM;
            FMT_LOAD: return OPC_LOAD;
            default:  return OPC_STORE;
        endcase
    endfunction

    // Register fields used by a format: {rs2, rs1, rd}
    function automatic logic [2:0] fmt_reg_use(input int f);
        case (f)
            FMT_REG:  return 3'b111;
            FMT_IMM:  return 3'b011;
            FMT_LOAD: return 3'b011;
            default:  return 3'b110;
        endcase
    endfunction
endpackage

// File: rtl/ilc_field_split.sv
module ilc_field_split
    import ilc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output insn_fields_t      fields
);
    assign fields = insn_fields_t'(word);
endmodule

// File: rtl/ilc_format_gate.sv
module ilc_format_gate
    import ilc_pkg::*;
#(
    parameter int NUM_REGS  = 32,
    parameter bit HALF_REGS = 1'b1
) (
    input  logic [6:0]           opcode,
    input  logic [4:0]           rd,
    input  logic [4:0]           rs1,
    input  logic [4:0]           rs2,
    output logic [NUM_GATED-1:0] fmt_ok
);
    localparam int LIMIT = NUM_REGS / 2;

    logic rd_ok, rs1_ok, rs2_ok;

    generate
        if (HALF_REGS) begin : g_half
            assign rd_ok  = int'(rd)  < LIMIT;
            assign rs1_ok = int'(rs1) < LIMIT;
            assign rs2_ok = int'(rs2) < LIMIT;
        end else begin : g_full
            assign rd_ok  = 1'b1;
            assign rs1_ok = 1'b1;
            assign rs2_ok = 1'b1;
        end

        for (genvar f = 0; f < NUM_GATED; f++) begin : g_fmt
            localparam logic [2:0] USE = fmt_reg_use(f);
            assign fmt_ok[f] = (opcode == fmt_opcode(f))
                             && (!USE[0] || rd_ok)
                             && (!USE[1] || rs1_ok)
                             && (!USE[2] || rs2_ok);
        end
    endgenerate
endmodule

// File: rtl/ilc_insn_match.sv
module ilc_insn_match
    import ilc_pkg::*;
(
    input  insn_fields_t         fields,
    input  logic [NUM_GATED-1:0] fmt_ok,
    output logic [NUM_FMT-1:0]   allowed
);
    localparam logic [6:0] F7_BASE = 7'h00;
    localparam logic [6:0] F7_ALT  = 7'h20;

    logic m_add_sub, m_and, m_or, m_xor;
    logic m_addi, m_andi, m_ori, m_xori;
    logic m_lw, m_sw, m_nop;
    logic f7_either;

    // Several permitted constants for one field: ORed first
    assign f7_either = (fields.funct7 == F7_BASE) || (fields.funct7 == F7_ALT);

    assign m_add_sub = fmt_ok[FMT_REG] && (fields.funct3 == 3'b000) && f7_either;
    assign m_and     = fmt_ok[FMT_REG] && (fields.funct3 == 3'b111) && (fields.funct7 == F7_BASE);
    assign m_or      = fmt_ok[FMT_REG] && (fields.funct3 == 3'b110) && (fields.funct7 == F7_BASE);
    assign m_xor     = fmt_ok[FMT_REG] && (fields.funct3 == 3'b100) && (fields.funct7 == F7_BASE);

    assign m_addi    = fmt_ok[FMT_IMM] && (fields.funct3 == 3'b000);
    assign m_andi    = fmt_ok[FMT_IMM] && (fields.funct3 == 3'b111);
    assign m_ori     = fmt_ok[FMT_IMM] && (fields.funct3 == 3'b110);
    assign m_xori    = fmt_ok[FMT_IMM] && (fields.funct3 == 3'b100);

    assign m_lw      = fmt_ok[FMT_LOAD]  && (fields.funct3 == 3'b010);
    assign m_sw      = fmt_ok[FMT_STORE] && (fields.funct3 == 3'b010);

    // No-op: field equalities only, no gate term
    assign m_nop     = (fields.opcode == OPC_IMM) && (fields.rd == 5'd0)
                    && (fields.funct3 == 3'b000) && (fields.rs1 == 5'd0)
                    && ({fields.funct7, fields.rs2} == 12'd0);

    assign allowed[FMT_REG]   = m_add_sub || m_and || m_or || m_xor;
    assign allowed[FMT_IMM]   = m_addi || m_andi || m_ori || m_xori;
    assign allowed[FMT_LOAD]  = m_lw;
    assign allowed[FMT_STORE] = m_sw;
    assign allowed[FMT_NOP]   = m_nop;
endmodule

// File: rtl/ilc_legality_checker.sv
module ilc_legality_checker
    import ilc_pkg::*;
#(
    parameter int NUM_REGS  = 32,
    parameter bit HALF_REGS = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  instr,
    output logic [NUM_FMT-1:0] fmt_allowed,
    output logic               legal
);
    insn_fields_t         fields;
    logic [NUM_GATED-1:0] fmt_ok;
    logic [NUM_FMT-1:0]   allowed_d;

    ilc_field_split u_split (
        .word   (instr),
        .fields (fields)
    );

    ilc_format_gate #(
        .NUM_REGS  (NUM_REGS),
        .HALF_REGS (HALF_REGS)
    ) u_gate (
        .opcode (fields.opcode),
        .rd     (fields.rd),
        .rs1    (fields.rs1),
        .rs2    (fields.rs2),
        .fmt_ok (fmt_ok)
    );

    ilc_insn_match u_match (
        .fields  (fields),
        .fmt_ok  (fmt_ok),
        .allowed (allowed_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_allowed <= '0;
            legal       <= 1'b0;
        end else begin
            fmt_allowed <= allowed_d;
            legal       <= |allowed_d;
        end
    end
endmodule

// File: rtl/ilc_checker_sva.sv
module ilc_checker_sva
    import ilc_pkg::*;
#(
    parameter int NUM_REGS      = 32,
    parameter bit HALF_REGS     = 1'b1,
    parameter bit ENFORCE_LEGAL = 1'b0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [WORD_W-1:0]  instr,
    input logic [NUM_FMT-1:0] fmt_allowed,
    input logic               legal
);
    localparam int LIMIT = NUM_REGS / 2;

    logic known_opc;
    assign known_opc = (instr[6:0] == OPC_REG) || (instr[6:0] == OPC_IMM)
                    || (instr[6:0] == OPC_LOAD) || (instr[6:0] == OPC_STORE);

    p_single_format_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fmt_allowed[NUM_GATED-1:0]));

    p_ldst_funct3_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((instr[6:0] == OPC_LOAD || instr[6:0] == OPC_STORE) && instr[14:12] != 3'b010)
        |=> !legal);

    p_nop_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr == 32'h0000_0013) |=> (fmt_allowed[FMT_NOP] && legal));

    p_legal_is_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
        legal == (|fmt_allowed));

    p_unknown_opcode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !known_opc |=> !legal);

    generate
        if (HALF_REGS) begin : g_half
            p_reg_rd_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (instr[6:0] == OPC_REG && int'(instr[11:7]) >= LIMIT)
                |=> !fmt_allowed[FMT_REG]);
        end
        if (ENFORCE_LEGAL) begin : g_enforce
            p_constraint_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
                legal);
        end
    endgenerate
endmodule

bind ilc_legality_checker ilc_checker_sva #(
    .NUM_REGS  (NUM_REGS),
    .HALF_REGS (HALF_REGS)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr       (instr),
    .fmt_allowed (fmt_allowed),
    .legal       (legal)
);

// File: tb/sim_ilc_legality_checker.sv
module sim_ilc_legality_checker;
    localparam int LIM = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] instr;
    logic [4:0]  fmt_allowed;
    logic        legal;

    int checks = 0;
    int fails  = 0;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    ilc_legality_checker u0 (
        .clk(clk), .rst_n(rst_n), .instr(instr),
        .fmt_allowed(fmt_allowed), .legal(legal)
    );

    // Expected {fmt_allowed, legal} from the requirements
    function automatic logic [5:0] model(input logic [31:0] w);
        logic [6:0] op = w[6:0];
        logic [2:0] f3 = w[14:12];
        logic [6:0] f7 = w[31:25];
        int rd = int'(w[11:7]);
        int r1 = int'(w[19:15]);
        int r2 = int'(w[24:20]);
        logic [4:0] a = '0;
        a[0] = (op == 7'h33) && rd < LIM && r1 < LIM && r2 < LIM &&
               ((f3 == 3'b000 && (f7 == 7'h00 || f7 == 7'h20)) ||
                (f7 == 7'h00 && (f3 == 3'b111 || f3 == 3'b110 || f3 == 3'b100)));
        a[1] = (op == 7'h13) && rd < LIM && r1 < LIM &&
               (f3 == 3'b000 || f3 == 3'b111 || f3 == 3'b110 || f3 == 3'b100);
        a[2] = (op == 7'h03) && rd < LIM && r1 < LIM && f3 == 3'b010;
        a[3] = (op == 7'h23) && r1 < LIM && r2 < LIM && f3 == 3'b010;
        a[4] = (w == 32'h0000_0013);
        return {a, |a};
    endfunction

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] r2,
                                          input logic [4:0] r1, input logic [2:0] f3,
                                          input logic [4:0] rd);
        return {f7, r2, r1, f3, rd, 7'h33};
    endfunction

    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] r1,
                                          input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [6:0] op);
        return {imm, r1, f3, rd, op};
    endfunction

    function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [4:0] r2,
                                          input logic [4:0] r1, input logic [2:0] f3);
        return {imm[11:5], r2, r1, f3, imm[4:0], 7'h23};
    endfunction

    task automatic drive(input logic [31:0] w, input string tag);
        @(negedge clk);
        instr = w;
        exp_q.push_back(model(w));
        tag_q.push_back(tag);
    endtask

    // Monitor: outputs after an edge belong to the word driven before it
    always @(posedge clk) begin
        #1;
        if (rst_n === 1'b1 && exp_q.size() > 0) begin
            logic [5:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({fmt_allowed, legal} !== e) begin
                fails++;
                $display("FAIL %s: got %b expected %b", t, {fmt_allowed, legal}, e);
            end
        end
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        instr = 32'h0000_0013;
        repeat (2) @(posedge clk);
        #1;
        checks++;
        if (fmt_allowed !== 5'b0) begin
            fails++;
            $display("FAIL R1 flags: got %b expected %b", fmt_allowed, 5'b0);
        end
        checks++;
        if (legal !== 1'b0) begin
            fails++;
            $display("FAIL R1 legal: got %b expected %b", legal, 1'b0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        drive(enc_r(7'h00, 5'd3, 5'd2, 3'b000, 5'd1), "R2 add");
        drive(enc_r(7'h00, 5'd7, 5'd6, 3'b111, 5'd5), "R2 and");
        drive(enc_r(7'h00, 5'd1, 5'd9, 3'b110, 5'd4), "R2 or");
        drive(enc_r(7'h00, 5'd2, 5'd8, 3'b100, 5'd15), "R2 xor");
        drive(enc_r(7'h20, 5'd3, 5'd2, 3'b000, 5'd1), "R3 sub alt funct7");
        drive(enc_r(7'h01, 5'd3, 5'd2, 3'b000, 5'd1), "R3 bad funct7");
        drive(enc_r(7'h20, 5'd3, 5'd2, 3'b111, 5'd1), "R3 alt funct7 on and");
        drive(enc_r(7'h00, 5'd3, 5'd2, 3'b001, 5'd1), "R3 bad funct3");
        drive(enc_i(12'hFFF, 5'd4, 3'b000, 5'd3, 7'h13), "R4 addi");
        drive(enc_i(12'h0F0, 5'd4, 3'b111, 5'd3, 7'h13), "R4 andi");
        drive(enc_i(12'h123, 5'd4, 3'b110, 5'd3, 7'h13), "R4 ori");
        drive(enc_i(12'h800, 5'd4, 3'b100, 5'd3, 7'h13), "R4 xori");
        drive(enc_i(12'h001, 5'd4, 3'b010, 5'd3, 7'h13), "R4 bad funct3");
        drive(enc_i(12'h010, 5'd2, 3'b010, 5'd7, 7'h03), "R5 lw");
        drive(enc_i(12'h010, 5'd2, 3'b000, 5'd7, 7'h03), "R5 load bad funct3");
        drive(enc_s(12'h024, 5'd5, 5'd6, 3'b010), "R5 sw");
        drive(enc_s(12'h024, 5'd5, 5'd6, 3'b001), "R5 store bad funct3");
        drive(enc_r(7'h00, 5'd3, 5'd2, 3'b000, 5'd16), "R6 rd 16");
        drive(enc_r(7'h00, 5'd31, 5'd2, 3'b000, 5'd1), "R6 rs2 31");
        drive(enc_r(7'h00, 5'd15, 5'd15, 3'b000, 5'd15), "R6 all 15");
        drive(enc_i(12'h000, 5'd15, 3'b000, 5'd2, 7'h13), "R6 rs1 15");
        drive(enc_i(12'h000, 5'd1, 3'b000, 5'd20, 7'h13), "R6 rd 20");
        drive(enc_s(12'h01F, 5'd2, 5'd3, 3'b010), "R6 store imm in rd slot");
        drive(enc_i(12'h01F, 5'd3, 3'b010, 5'd1, 7'h03), "R6 load imm in rs2 slot");
        drive(enc_s(12'h000, 5'd16, 5'd3, 3'b010), "R6 store rs2 16");
        drive(32'h0000_0013, "R7 nop word");
        drive(32'h0010_0013, "R7 near nop");
        drive(32'h0000_0037, "R8 unknown opcode");
        drive(32'hFFFF_FFFF, "R8 all ones");
        drive(32'h0000_0000, "R8 all zero");
        drive(enc_i(12'h010, 5'd2, 3'b010, 5'd7, 7'h03), "R9 legal then");
        drive(32'h0000_0037, "R9 illegal next");
        drive(enc_s(12'h004, 5'd1, 5'd1, 3'b010), "R9 legal again");

        @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule